// File: doc/BRIEF.md
# Serial Bus Master Transfer Sequencer

This block runs master-mode transfers on a two-wire serial bus one byte at a time. Software writes a control word and a byte count. The sequencer then asks a byte-level bus engine to send a start condition with the target address. It moves the programmed number of bytes between the engine and an external transmit or receive FIFO, and finally asks the engine for a stop condition. It does not generate bit timing, hold FIFO storage or mask interrupts. Those jobs belong to the blocks around it.

The count that software writes is kept as a shadow value. Each start copies it into a live counter, and every byte moved takes one from that counter. The live counter is visible on an output at all times. An access-ready pulse is raised when a byte brings the live count to zero. A NACK pulse is raised when the address phase or a transmitted byte is not acknowledged; after a NACK, no further bytes are moved until a stop is requested. A stop written on its own, with no start, ends the transaction at once.

Each engine request is a level held until the engine returns a one-cycle done pulse. The done pulse comes with an acknowledge flag and, for reads, a data byte.

Top module: `serial_xfer_seq`

## Requirements
- R1: A control write with enable (bit 15), master (bit 10) and start (bit 0) all set, while idle, raises the start request with the captured target address. The read flag on that request is the inverse of direction bit 9, where 1 means transmit. In the cycle after the write, the start bit reads back as 0.
- R2: On a start, the live count is loaded from the shadow count, and the live count is always shown on `cnt_live`.
- R3: If the engine completes the address phase with the acknowledge flag low, a one-cycle NACK pulse follows and no byte request is made until a stop is requested.
- R4: In transmit, a send request is made only while the live count is nonzero and the transmit FIFO is not empty. One FIFO byte is taken per send and presented on `eng_tx_data`, and each completed send decrements the live count.
- R5: In receive, a receive request is made only while the live count is nonzero and the receive FIFO is not full. Each completed receive pushes the engine byte into the FIFO and decrements the live count.
- R6: A one-cycle access-ready pulse is raised only when a completed byte brings the live count to zero. A transfer started with a count of zero raises no pulse.
- R7: A send completed with the acknowledge flag low gives a one-cycle NACK pulse, and no further send request follows.
- R8: When the live count is zero, or the transfer was halted by a NACK, and stop (bit 1) is set, a stop request is issued. In the same step, the master, direction and stop bits clear and the live count is reloaded from the shadow count. The sequencer returns to idle once the stop completes.
- R9: A write with stop set and start clear, while idle, issues a stop request immediately. It clears the master, direction and stop bits and reloads the live count.
- R10: While a transfer is running, a write with stop set only latches the stop bit, and any other control write has no effect.
- R11: A control write with enable clear aborts the transfer. All engine requests drop in the next cycle, and the control word takes the written value.
- R12: At most one engine request is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_q | output | 16 | Control word readback |
| cnt_we | input | 1 | Shadow count write strobe |
| cnt_wdata | input | CW | Shadow count write value |
| cnt_live | output | CW | Live remaining byte count |
| tgt_addr | input | AW | Target address, captured at start |
| eng_start_req | output | 1 | Start and address request to the engine |
| eng_addr | output | AW | Address for the start request |
| eng_read | output | 1 | Read flag for the start request |
| eng_tx_req | output | 1 | Send-byte request |
| eng_tx_data | output | DW | Byte to send |
| eng_rx_req | output | 1 | Receive-byte request |
| eng_stop_req | output | 1 | Stop request |
| eng_done | input | 1 | One-cycle completion of the held request |
| eng_ack | input | 1 | Acknowledge flag qualifying eng_done |
| eng_rx_data | input | DW | Received byte qualifying eng_done |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | DW | Transmit FIFO head byte |
| txf_pop | output | 1 | Transmit FIFO head consumed |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_push | output | 1 | Receive FIFO write strobe |
| rxf_data | output | DW | Receive FIFO write byte |
| ev_ardy | output | 1 | Access-ready pulse |
| ev_nack | output | 1 | NACK pulse |

## Verification
The checker assumes that the engine raises `eng_done` only while a request is held, and only once per request. It also assumes that `eng_ack` and `eng_rx_data` are valid whenever `eng_done` is high, and that the FIFO flags change only when this block pops or pushes. The bench engine answers a held request after a fixed latency with one done pulse, and it lowers done on the next cycle. The bench FIFOs update their flags from the block's own pop and push strobes. Aborts are issued only while no engine handshake is pending, so no done pulse ever arrives for a request that has already been dropped.

// File: rtl/serial_xfer_seq.sv
module serial_xfer_seq #(
  parameter int CW = 16,
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [15:0]   ctl_wdata,
  output logic [15:0]   ctl_q,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  output logic [CW-1:0] cnt_live,
  input  logic [AW-1:0] tgt_addr,
  output logic          eng_start_req,
  output logic [AW-1:0] eng_addr,
  output logic          eng_read,
  output logic          eng_tx_req,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_rx_req,
  output logic          eng_stop_req,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          txf_empty,
  input  logic [DW-1:0] txf_data,
  output logic          txf_pop,
  input  logic          rxf_full,
  output logic          rxf_push,
  output logic [DW-1:0] rxf_data,
  output logic          ev_ardy,
  output logic          ev_nack
);
  localparam int B_GO = 0, B_END = 1, B_XMT = 9, B_MST = 10, B_ON = 15;
  localparam logic [15:0] CTL_MASK = 16'h8603;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_RUN, PH_SEND, PH_RECV, PH_STOP} phase_t;

  phase_t        ph;
  logic [CW-1:0] shadow;
  logic          halted;

  wire wr_abort = ctl_we && !ctl_wdata[B_ON];
  wire wr_stop  = ctl_we && ctl_wdata[B_END];
  wire at_end   = (cnt_live == '0) || halted;

  assign eng_start_req = (ph == PH_ADDR);
  assign eng_tx_req    = (ph == PH_SEND);
  assign eng_rx_req    = (ph == PH_RECV);
  assign eng_stop_req  = (ph == PH_STOP);
  assign eng_read      = !ctl_q[B_XMT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph          <= PH_IDLE;
      ctl_q       <= '0;
      shadow      <= '0;
      cnt_live    <= '0;
      halted      <= 1'b0;
      eng_addr    <= '0;
      eng_tx_data <= '0;
      rxf_data    <= '0;
      txf_pop     <= 1'b0;
      rxf_push    <= 1'b0;
      ev_ardy     <= 1'b0;
      ev_nack     <= 1'b0;
    end else begin
      txf_pop  <= 1'b0;
      rxf_push <= 1'b0;
      ev_ardy  <= 1'b0;
      ev_nack  <= 1'b0;
      if (cnt_we) shadow <= cnt_wdata;
      if (wr_abort) begin
        ctl_q    <= ctl_wdata & CTL_MASK;
        ph       <= PH_IDLE;
        cnt_live <= shadow;
        halted   <= 1'b0;
      end else begin
        if (wr_stop && ph != PH_IDLE && ph != PH_STOP) ctl_q[B_END] <= 1'b1;
        unique case (ph)
          PH_IDLE: if (ctl_we) begin
            ctl_q <= ctl_wdata & CTL_MASK;
            if (ctl_wdata[B_MST] && ctl_wdata[B_GO]) begin
              ctl_q[B_GO] <= 1'b0;
              cnt_live    <= shadow;
              halted      <= 1'b0;
              eng_addr    <= tgt_addr;
              ph          <= PH_ADDR;
            end else if (ctl_wdata[B_END]) begin
              ctl_q[B_END] <= 1'b0;
              ctl_q[B_XMT] <= 1'b0;
              ctl_q[B_MST] <= 1'b0;
              cnt_live     <= shadow;
              ph           <= PH_STOP;
            end
          end
          PH_ADDR: if (eng_done) begin
            if (!eng_ack) begin
              ev_nack <= 1'b1;
              halted  <= 1'b1;
            end
            ph <= PH_RUN;
          end
          PH_RUN: begin
            if (ctl_q[B_END] && at_end) begin
              ctl_q[B_END] <= 1'b0;
              ctl_q[B_XMT] <= 1'b0;
              ctl_q[B_MST] <= 1'b0;
              cnt_live     <= shadow;
              ph           <= PH_STOP;
            end else if (!at_end) begin
              if (ctl_q[B_XMT]) begin
                if (!txf_empty) begin
                  eng_tx_data <= txf_data;
                  txf_pop     <= 1'b1;
                  ph          <= PH_SEND;
                end
              end else if (!rxf_full) begin
                ph <= PH_RECV;
              end
            end
          end
          PH_SEND: if (eng_done) begin
            cnt_live <= cnt_live - 1'b1;
            ev_ardy  <= (cnt_live == CW'(1));
            if (!eng_ack) begin
              ev_nack <= 1'b1;
              halted  <= 1'b1;
            end
            ph <= PH_RUN;
          end
          PH_RECV: if (eng_done) begin
            cnt_live <= cnt_live - 1'b1;
            ev_ardy  <= (cnt_live == CW'(1));
            rxf_data <= eng_rx_data;
            rxf_push <= 1'b1;
            ph       <= PH_RUN;
          end
          PH_STOP: if (eng_done) ph <= PH_IDLE;
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

module serial_xfer_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [15:0]   ctl_wdata,
  input logic [15:0]   ctl_q,
  input logic [CW-1:0] cnt_live,
  input logic          eng_start_req,
  input logic          eng_tx_req,
  input logic          eng_rx_req,
  input logic          eng_stop_req,
  input logic          eng_done,
  input logic          eng_ack,
  input logic          txf_pop,
  input logic          rxf_push,
  input logic          ev_ardy,
  input logic          ev_nack
);
  assert_one_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eng_start_req, eng_tx_req, eng_rx_req, eng_stop_req}));

  assert_start_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_req |-> !ctl_q[0]);

  assert_nack_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nack |-> $past(eng_done && !eng_ack && (eng_start_req || eng_tx_req)));

  assert_pop_with_send_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |-> eng_tx_req);

  assert_byte_decrements_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eng_done && (eng_tx_req || eng_rx_req) && !(ctl_we && !ctl_wdata[15]))
      |-> cnt_live == $past(cnt_live) - 1'b1);

  assert_push_after_recv_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> $past(eng_rx_req && eng_done));

  assert_ready_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ardy |-> cnt_live == '0);

  assert_stop_clears_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop_req |-> !ctl_q[1] && !ctl_q[10] && !ctl_q[9]);

  assert_abort_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[15]) |=> !(eng_start_req || eng_tx_req || eng_rx_req || eng_stop_req));
endmodule

bind serial_xfer_seq serial_xfer_seq_chk #(.CW(CW)) u_chk (.*);

// File: tb/tb_serial_xfer_seq.sv
module tb_serial_xfer_seq;
  localparam int CW = 16, AW = 10, DW = 8;
  localparam int RXCAP = 2;
  localparam int LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, cnt_we = 1'b0;
  logic [15:0] ctl_wdata = '0, ctl_q;
  logic [CW-1:0] cnt_wdata = '0, cnt_live;
  logic [AW-1:0] tgt_addr = 10'h2A5, eng_addr;
  logic eng_start_req, eng_read, eng_tx_req, eng_rx_req, eng_stop_req;
  logic [DW-1:0] eng_tx_data, rxf_data;
  logic eng_done = 1'b0, eng_ack = 1'b1;
  logic [DW-1:0] eng_rx_data = '0, txf_data = '0;
  logic txf_empty = 1'b1, rxf_full = 1'b0;
  logic txf_pop, rxf_push, ev_ardy, ev_nack;

  always #5 clk = ~clk;

  serial_xfer_seq #(.CW(CW), .AW(AW), .DW(DW)) dut (.*);

  int vecs = 0, bad = 0, cycles = 0;
  byte txq[$], rxq[$], sent[$];
  int lat = 0, byte_idx = 0, nack_byte = 0, ardy_seen = 0, nack_seen = 0;
  bit nack_addr = 0;
  byte rx_gen = 8'h40;

  // behavioural reference: phase 0 idle,1 addr,2 run,3 send,4 recv,5 stop
  int m_ph;
  logic [15:0] m_ctl;
  logic [CW-1:0] m_live, m_shadow;
  bit m_halt, m_ardy, m_nack, m_pop, m_push;
  logic [DW-1:0] m_txb, m_rxb;
  logic [AW-1:0] m_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ctl = 0; m_live = 0; m_shadow = 0; m_halt = 0;
      m_ardy = 0; m_nack = 0; m_pop = 0; m_push = 0; m_txb = 0; m_rxb = 0; m_addr = 0;
    end else begin
      logic [CW-1:0] old_shadow;
      old_shadow = m_shadow;
      m_ardy = 0; m_nack = 0; m_pop = 0; m_push = 0;
      if (ctl_we && !ctl_wdata[15]) begin
        m_ctl = ctl_wdata & 16'h8603; m_ph = 0; m_live = old_shadow; m_halt = 0;
      end else if (m_ph == 0) begin
        if (ctl_we) begin
          m_ctl = ctl_wdata & 16'h8603;
          if (ctl_wdata[10] && ctl_wdata[0]) begin
            m_ctl[0] = 0; m_live = old_shadow; m_halt = 0; m_addr = tgt_addr; m_ph = 1;
          end else if (ctl_wdata[1]) begin
            m_ctl = m_ctl & ~16'h0602; m_live = old_shadow; m_ph = 5;
          end
        end
      end else begin
        bit finish;
        finish = (m_ph == 2) && m_ctl[1] && (m_live == 0 || m_halt);
        if (ctl_we && ctl_wdata[1] && m_ph != 5) m_ctl[1] = 1;
        if (finish) begin
          m_ctl = m_ctl & ~16'h0602; m_live = old_shadow; m_ph = 5;
        end else if (m_ph == 1) begin
          if (eng_done) begin
            if (!eng_ack) begin m_nack = 1; m_halt = 1; end
            m_ph = 2;
          end
        end else if (m_ph == 2) begin
          if (m_live != 0 && !m_halt) begin
            if (m_ctl[9] && !txf_empty) begin m_txb = txf_data; m_pop = 1; m_ph = 3; end
            else if (!m_ctl[9] && !rxf_full) m_ph = 4;
          end
        end else if (m_ph == 3 || m_ph == 4) begin
          if (eng_done) begin
            m_ardy = (m_live == 1);
            m_live = m_live - 1;
            if (m_ph == 3 && !eng_ack) begin m_nack = 1; m_halt = 1; end
            if (m_ph == 4) begin m_rxb = eng_rx_data; m_push = 1; end
            m_ph = 2;
          end
        end else if (m_ph == 5) begin
          if (eng_done) m_ph = 0;
        end
      end
      if (cnt_we) m_shadow = cnt_wdata;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    if (cycles > LIMIT) begin
      check(0, "R12", "watchdog expired", cycles, LIMIT);
      finish_run();
    end
    if (rst_n) begin
      check(ctl_q == m_ctl, "R1", "control word", ctl_q, m_ctl);
      check(cnt_live == m_live, "R2", "live count", cnt_live, m_live);
      check(eng_start_req == (m_ph == 1), "R1", "start request", eng_start_req, m_ph == 1);
      check(eng_tx_req == (m_ph == 3), "R4", "send request", eng_tx_req, m_ph == 3);
      check(eng_rx_req == (m_ph == 4), "R5", "receive request", eng_rx_req, m_ph == 4);
      check(eng_stop_req == (m_ph == 5), "R8", "stop request", eng_stop_req, m_ph == 5);
      check(ev_ardy == m_ardy, "R6", "ready pulse", ev_ardy, m_ardy);
      check(ev_nack == m_nack, "R7", "nack pulse", ev_nack, m_nack);
      check(txf_pop == m_pop, "R4", "pop strobe", txf_pop, m_pop);
      check(rxf_push == m_push, "R5", "push strobe", rxf_push, m_push);
      if (m_ph == 3) check(eng_tx_data == m_txb, "R4", "send byte", eng_tx_data, m_txb);
      if (m_push) check(rxf_data == m_rxb, "R5", "receive byte", rxf_data, m_rxb);
      if (m_ph == 1) begin
        check(eng_addr == m_addr, "R1", "address", eng_addr, m_addr);
        check(eng_read == !m_ctl[9], "R1", "read flag", eng_read, !m_ctl[9]);
      end
    end
    if (ev_ardy) ardy_seen++;
    if (ev_nack) nack_seen++;
    if (txf_pop && txq.size() > 0) void'(txq.pop_front());
    if (rxf_push) rxq.push_back(rxf_data);
    txf_empty = (txq.size() == 0);
    txf_data  = (txq.size() > 0) ? txq[0] : 8'h00;
    rxf_full  = (rxq.size() >= RXCAP);
    if (eng_done) begin
      eng_done = 0; lat = 0;
    end else if (eng_start_req || eng_tx_req || eng_rx_req || eng_stop_req) begin
      lat++;
      if (lat >= 2) begin
        eng_done = 1; eng_ack = 1;
        if (eng_start_req) eng_ack = !nack_addr;
        if (eng_tx_req) begin
          byte_idx++; sent.push_back(eng_tx_data);
          eng_ack = (byte_idx != nack_byte);
        end
        if (eng_rx_req) begin eng_rx_data = rx_gen; rx_gen++; end
      end
    end
    ctl_we = 0; cnt_we = 0;
  endtask

  task automatic wr_ctl(input logic [15:0] v);
    ctl_wdata = v; ctl_we = 1; tick();
  endtask

  task automatic wr_cnt(input logic [CW-1:0] v);
    cnt_wdata = v; cnt_we = 1; tick();
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 500 && quiet < 4; i++) begin
      tick();
      if (!ctl_q[10] && !eng_start_req && !eng_tx_req && !eng_rx_req && !eng_stop_req) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic fresh();
    ardy_seen = 0; nack_seen = 0; byte_idx = 0; nack_byte = 0; nack_addr = 0;
    sent.delete();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    check(ctl_q == 16'h0 && cnt_live == 0, "R2", "reset state", {ctl_q, cnt_live}, 0);
    check(!(eng_start_req || eng_tx_req || eng_rx_req || eng_stop_req), "R12", "reset requests", 1, 0);

    // transmit of three bytes with stop
    fresh();
    txq = '{8'hA1, 8'hB2, 8'hC3};
    wr_cnt(3);
    wr_ctl(16'h8603);
    check(eng_start_req && !ctl_q[0], "R1", "start issued, start bit clear", ctl_q, 16'h8602);
    check(cnt_live == 3, "R2", "live loaded", cnt_live, 3);
    wait_idle();
    check(sent.size() == 3 && sent[0] == 8'hA1 && sent[2] == 8'hC3, "R4", "bytes sent in order", sent.size(), 3);
    check(ardy_seen == 1, "R6", "one ready pulse", ardy_seen, 1);
    check(ctl_q == 16'h8000 && cnt_live == 3, "R8", "bits cleared, count reloaded", ctl_q, 16'h8000);

    // receive of four bytes, FIFO fills at two
    fresh(); rxq.delete(); rx_gen = 8'h40;
    wr_cnt(4);
    wr_ctl(16'h8403);
    repeat (20) tick();
    check(cnt_live == 2 && !eng_rx_req, "R5", "stalled on full FIFO", cnt_live, 2);
    rxq.delete();
    wait_idle();
    check(rxq.size() == 2 && rxq[0] == 8'h42 && rxq[1] == 8'h43, "R5", "later bytes received", rxq.size(), 2);
    check(ardy_seen == 1 && cnt_live == 4, "R6", "ready after receive", ardy_seen, 1);
    rxq.delete();

    // NACK on second transmitted byte, stop written afterwards
    fresh(); nack_byte = 2;
    txq = '{8'h11, 8'h22, 8'h33, 8'h44};
    wr_cnt(4);
    wr_ctl(16'h8601);
    repeat (25) tick();
    check(nack_seen == 1 && cnt_live == 2, "R7", "halt after nack", cnt_live, 2);
    check(sent.size() == 2 && !eng_tx_req, "R7", "no further sends", sent.size(), 2);
    wr_ctl(16'h8002);
    tick();
    check(eng_stop_req && ctl_q == 16'h8000 && cnt_live == 4, "R10", "latched stop ends transfer", ctl_q, 16'h8000);
    wait_idle();
    txq.delete();

    // address NACK, ignored write, then abort
    fresh(); nack_addr = 1;
    txq = '{8'h55, 8'h66};
    wr_cnt(2);
    wr_ctl(16'h8601);
    repeat (10) tick();
    check(nack_seen == 1 && cnt_live == 2 && sent.size() == 0, "R3", "address nack, no bytes", nack_seen, 1);
    wr_ctl(16'h8401);
    check(ctl_q == 16'h8600 && !eng_start_req, "R10", "busy write ignored", ctl_q, 16'h8600);
    wr_ctl(16'h0000);
    check(ctl_q == 16'h0 && !(eng_start_req || eng_tx_req || eng_rx_req || eng_stop_req), "R11", "abort to idle", ctl_q, 0);
    repeat (4) tick();
    check(sent.size() == 0 && cnt_live == 2, "R11", "nothing moves after abort", sent.size(), 0);
    txq.delete();

    // stop alone while idle
    fresh();
    wr_cnt(5);
    wr_ctl(16'h8002);
    check(eng_stop_req && ctl_q == 16'h8000 && cnt_live == 5, "R9", "immediate stop", ctl_q, 16'h8000);
    wait_idle();

    // transmit waits on empty FIFO
    fresh();
    wr_cnt(2);
    wr_ctl(16'h8603);
    repeat (20) tick();
    check(!eng_tx_req && cnt_live == 2 && eng_rx_req == 0, "R4", "no send while FIFO empty", cnt_live, 2);
    txq = '{8'h77, 8'h88};
    wait_idle();
    check(sent.size() == 2 && ardy_seen == 1 && ctl_q == 16'h8000, "R4", "send resumes", sent.size(), 2);

    // zero-count transfer
    fresh();
    wr_cnt(0);
    wr_ctl(16'h8603);
    wait_idle();
    check(ardy_seen == 0 && sent.size() == 0, "R6", "no ready at zero count", ardy_seen, 0);
    check(ctl_q == 16'h8000, "R8", "zero-count stop", ctl_q, 16'h8000);

    finish_run();
  end
endmodule